// File: doc/BRIEF.md
# Parallel NOR Flash Program and Erase Controller

This block is the host side of a byte-wide parallel NOR flash bus. A client asks for one of three operations: byte program, sector erase or chip erase. The request carries the operation code, the target address and the data byte. The controller then writes the unlock and command bytes the flash expects. Each of those writes is a timed cycle in which the chip-enable and write-enable strobes are low. When the last command write has finished, the controller reads the target address again and again until the flash reports that the operation has finished.

Two completion tests are supported, and an input picks one of them for each request. In the first, the controller compares the top data bit with the value expected when the operation is complete. In the second, it compares bit 6 of each read with bit 6 of the read before it. The controller counts the clock cycles spent polling. If that count reaches a limit before the flash reports completion, the operation ends with an error. A program uses one limit and both erases use another. The outcome is returned as a one-clock done pulse, with an error flag that is valid in the same cycle.

Top module: `nor_pe_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, fl_ce_n, fl_we_n and fl_oe_n are 1, fl_dq_oe is 0, and busy, done and err are 0.
- R2: Operation code 0 (byte program) writes, in this order: AAh to 5555h, 55h to 2AAAh, A0h to 5555h, then the request data to the request address.
- R3: Operation code 1 (sector erase) writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h and 55h@2AAAh, then 30h to the request address.
- R4: Operation code 2 (chip erase) writes the same first five bytes as R3, then 10h to 5555h.
- R5: In every write cycle, fl_ce_n and fl_we_n are low for exactly WR_PULSE clocks, fl_oe_n is high and fl_dq_oe is 1. Between any two bus cycles, fl_ce_n stays high for at least GAP clocks.
- R6: Each poll read holds fl_ce_n and fl_oe_n low for exactly RD_PULSE clocks, with fl_we_n high and fl_dq_oe 0, and uses the request address.
- R7: With poll_toggle=0, the operation ends with err=0 on the first read whose bit 7 is the expected value: bit 7 of the request data for a program, or 1 for either erase.
- R8: With poll_toggle=1, the operation ends with err=0 on the first read whose bit 6 equals bit 6 of the read just before it. The first read of an operation never ends it.
- R9: The controller counts clocks from the start of polling. The check is made at the end of each read. If that read does not show completion and the count has reached TMO_PROG (program) or TMO_ERASE (either erase), the operation ends with err=1.
- R10: busy goes high in the cycle after a request is accepted and falls in the same cycle that done is high. done is high for exactly one clock, and err is valid in that cycle.
- R11: A req_valid that arrives while busy is high is ignored. It adds no bus cycle and does not change the outcome of the operation in progress.
- R12: Operation code 3 is rejected. done and err are high in the cycle after the request, and no bus cycle takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Start pulse; accepted only while idle |
| req_op | input | 2 | Operation: 0 program, 1 sector erase, 2 chip erase, 3 invalid |
| req_addr | input | AW | Program address or sector address |
| req_data | input | 8 | Byte to program |
| poll_toggle | input | 1 | Completion test: 0 for bit-7 compare, 1 for bit-6 toggle |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-clock pulse when an operation ends |
| err | output | 1 | Timeout or rejected request; valid while done is high |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_addr | output | AW | Flash address |
| fl_dq_o | output | 8 | Data driven onto the flash bus |
| fl_dq_oe | output | 1 | Drive enable for fl_dq_o |
| fl_dq_i | input | 8 | Data read from the flash bus |

## Verification
Every output is registered, so a request driven at a falling edge is seen at the next rising edge. busy, or done with err for the rejected code, can therefore be checked at the falling edge that follows the request. The bench counts the falling edges at which each strobe is low and expects exactly WR_PULSE for a write and RD_PULSE for a read. It expects the ending read to be exactly read B+1 for a bit-7 poll, or the first repeat of bit 6 for a toggle poll, where B is the number of reads for which the bench's flash model reports busy. It takes the outcome only at the falling edge where done is seen and checks at the next falling edge that done has dropped. A timeout is due no earlier than the limit and within a bounded window after it. The bench checks that window against the latency it measured from the request.

// File: rtl/nor_pe_pkg.sv
package nor_pe_pkg;
  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_CHIP = 2'd2,
    OP_BAD  = 2'd3
  } op_e;

  localparam logic [15:0] UNLK_A    = 16'h5555;
  localparam logic [15:0] UNLK_B    = 16'h2AAA;
  localparam logic [7:0]  KEY_1     = 8'hAA;
  localparam logic [7:0]  KEY_2     = 8'h55;
  localparam logic [7:0]  CMD_PROG  = 8'hA0;
  localparam logic [7:0]  CMD_ERASE = 8'h80;
  localparam logic [7:0]  CMD_SECT  = 8'h30;
  localparam logic [7:0]  CMD_CHIP  = 8'h10;
endpackage

// File: rtl/nor_bus_cycle.sv
module nor_bus_cycle #(
  parameter int AW       = 19,
  parameter int WR_PULSE = 3,
  parameter int RD_PULSE = 2,
  parameter int GAP      = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue,
  input  logic          is_rd,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic          fl_ce_n,
  output logic          fl_we_n,
  output logic          fl_oe_n,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_dq_o,
  output logic          fl_dq_oe,
  input  logic [7:0]    fl_dq_i,
  output logic [7:0]    rdata,
  output logic          fin
);
  localparam int MX1 = (WR_PULSE > RD_PULSE) ? WR_PULSE : RD_PULSE;
  localparam int MX  = (MX1 > GAP) ? MX1 : GAP;
  localparam int CW  = $clog2(MX + 1);

  typedef enum logic [1:0] {B_IDLE, B_PULSE, B_GAP} bst_e;
  bst_e          st;
  logic [CW-1:0] cnt;
  logic          rd_q;
  logic [CW-1:0] pulse_last;

  assign pulse_last = rd_q ? CW'(RD_PULSE - 1) : CW'(WR_PULSE - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= B_IDLE;
      cnt      <= '0;
      rd_q     <= 1'b0;
      fl_ce_n  <= 1'b1;
      fl_we_n  <= 1'b1;
      fl_oe_n  <= 1'b1;
      fl_addr  <= '0;
      fl_dq_o  <= '0;
      fl_dq_oe <= 1'b0;
      rdata    <= '0;
      fin      <= 1'b0;
    end else begin
      fin <= 1'b0;
      case (st)
        B_IDLE: if (issue) begin
          fl_ce_n  <= 1'b0;
          fl_we_n  <= is_rd;
          fl_oe_n  <= !is_rd;
          fl_addr  <= addr;
          fl_dq_o  <= wdata;
          fl_dq_oe <= !is_rd;
          rd_q     <= is_rd;
          cnt      <= '0;
          st       <= B_PULSE;
        end
        B_PULSE: begin
          if (cnt == pulse_last) begin
            fl_ce_n  <= 1'b1;
            fl_we_n  <= 1'b1;
            fl_oe_n  <= 1'b1;
            fl_dq_oe <= 1'b0;
            if (rd_q) rdata <= fl_dq_i;
            cnt <= '0;
            st  <= B_GAP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (cnt == CW'(GAP - 1)) begin
            fin <= 1'b1;
            st  <= B_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/nor_poll_eval.sv
module nor_poll_eval (
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic       sample,
  input  logic       toggle_mode,
  input  logic       expect7,
  input  logic [7:0] rdata,
  output logic       ok
);
  logic prev6;
  logic have_prev;

  assign ok = toggle_mode ? (have_prev && (rdata[6] == prev6))
                          : (rdata[7] == expect7);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      prev6     <= 1'b0;
      have_prev <= 1'b0;
    end else if (sample) begin
      prev6     <= rdata[6];
      have_prev <= 1'b1;
    end
  end
endmodule

// File: rtl/nor_pe_seq.sv
module nor_pe_seq
  import nor_pe_pkg::*;
#(
  parameter int AW        = 19,
  parameter int TMO_PROG  = 1750,
  parameter int TMO_ERASE = 150000000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_data,
  input  logic          poll_toggle,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          issue,
  output logic          is_rd,
  output logic [AW-1:0] cyc_addr,
  output logic [7:0]    cyc_data,
  input  logic          fin,
  input  logic          poll_ok,
  output logic          poll_clear,
  output logic          poll_sample,
  output logic          toggle_q,
  output logic          expect7
);
  localparam int TMAX = (TMO_PROG > TMO_ERASE) ? TMO_PROG : TMO_ERASE;
  localparam int TW   = $clog2(TMAX + 2);

  typedef enum logic [2:0] {S_IDLE, S_WISSUE, S_WWAIT, S_RISSUE, S_RWAIT} st_e;
  st_e           st;
  op_e           op_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic [2:0]    widx;
  logic [TW-1:0] tmo_cnt;
  logic [2:0]    last_idx;
  logic [TW-1:0] limit;

  function automatic logic [AW+7:0] step(op_e op, logic [2:0] i,
                                         logic [AW-1:0] a, logic [7:0] d);
    logic [AW-1:0] ua, ub;
    ua = AW'(UNLK_A);
    ub = AW'(UNLK_B);
    case (i)
      3'd0:    step = {ua, KEY_1};
      3'd1:    step = {ub, KEY_2};
      3'd2:    step = (op == OP_PROG) ? {ua, CMD_PROG} : {ua, CMD_ERASE};
      3'd3:    step = (op == OP_PROG) ? {a, d} : {ua, KEY_1};
      3'd4:    step = {ub, KEY_2};
      default: step = (op == OP_SECT) ? {a, CMD_SECT} : {ua, CMD_CHIP};
    endcase
  endfunction

  assign last_idx    = (op_q == OP_PROG) ? 3'd3 : 3'd5;
  assign limit       = (op_q == OP_PROG) ? TW'(TMO_PROG) : TW'(TMO_ERASE);
  assign expect7     = (op_q == OP_PROG) ? data_q[7] : 1'b1;
  assign poll_clear  = (st == S_WWAIT) && fin && (widx == last_idx);
  assign poll_sample = (st == S_RWAIT) && fin;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      op_q     <= OP_PROG;
      addr_q   <= '0;
      data_q   <= '0;
      toggle_q <= 1'b0;
      widx     <= '0;
      tmo_cnt  <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      issue    <= 1'b0;
      is_rd    <= 1'b0;
      cyc_addr <= '0;
      cyc_data <= '0;
    end else begin
      done  <= 1'b0;
      issue <= 1'b0;
      if ((st == S_RISSUE || st == S_RWAIT) && tmo_cnt != '1)
        tmo_cnt <= tmo_cnt + 1'b1;
      case (st)
        S_IDLE: if (req_valid) begin
          if (req_op == OP_BAD) begin
            done <= 1'b1;
            err  <= 1'b1;
          end else begin
            busy     <= 1'b1;
            op_q     <= op_e'(req_op);
            addr_q   <= req_addr;
            data_q   <= req_data;
            toggle_q <= poll_toggle;
            widx     <= '0;
            st       <= S_WISSUE;
          end
        end
        S_WISSUE: begin
          issue                <= 1'b1;
          is_rd                <= 1'b0;
          {cyc_addr, cyc_data} <= step(op_q, widx, addr_q, data_q);
          st                   <= S_WWAIT;
        end
        S_WWAIT: if (fin) begin
          if (widx == last_idx) begin
            tmo_cnt <= '0;
            st      <= S_RISSUE;
          end else begin
            widx <= widx + 1'b1;
            st   <= S_WISSUE;
          end
        end
        S_RISSUE: begin
          issue    <= 1'b1;
          is_rd    <= 1'b1;
          cyc_addr <= addr_q;
          cyc_data <= '0;
          st       <= S_RWAIT;
        end
        default: if (fin) begin
          if (poll_ok) begin
            done <= 1'b1;
            err  <= 1'b0;
            busy <= 1'b0;
            st   <= S_IDLE;
          end else if (tmo_cnt >= limit) begin
            done <= 1'b1;
            err  <= 1'b1;
            busy <= 1'b0;
            st   <= S_IDLE;
          end else begin
            st <= S_RISSUE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/nor_pe_ctrl.sv
module nor_pe_ctrl #(
  parameter int AW        = 19,
  parameter int WR_PULSE  = 3,
  parameter int RD_PULSE  = 2,
  parameter int GAP       = 2,
  parameter int TMO_PROG  = 1750,
  parameter int TMO_ERASE = 150000000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_data,
  input  logic          poll_toggle,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          fl_ce_n,
  output logic          fl_we_n,
  output logic          fl_oe_n,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_dq_o,
  output logic          fl_dq_oe,
  input  logic [7:0]    fl_dq_i
);
  logic          issue, is_rd, fin, poll_ok, poll_clear, poll_sample;
  logic          toggle_q, expect7;
  logic [AW-1:0] cyc_addr;
  logic [7:0]    cyc_data, rdata;

  nor_pe_seq #(.AW(AW), .TMO_PROG(TMO_PROG), .TMO_ERASE(TMO_ERASE)) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .poll_toggle(poll_toggle),
    .busy(busy), .done(done), .err(err), .issue(issue), .is_rd(is_rd),
    .cyc_addr(cyc_addr), .cyc_data(cyc_data), .fin(fin), .poll_ok(poll_ok),
    .poll_clear(poll_clear), .poll_sample(poll_sample),
    .toggle_q(toggle_q), .expect7(expect7)
  );

  nor_bus_cycle #(.AW(AW), .WR_PULSE(WR_PULSE), .RD_PULSE(RD_PULSE), .GAP(GAP)) u_bus (
    .clk(clk), .rst(rst), .issue(issue), .is_rd(is_rd), .addr(cyc_addr),
    .wdata(cyc_data), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n),
    .fl_addr(fl_addr), .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe),
    .fl_dq_i(fl_dq_i), .rdata(rdata), .fin(fin)
  );

  nor_poll_eval u_poll (
    .clk(clk), .rst(rst), .clear(poll_clear), .sample(poll_sample),
    .toggle_mode(toggle_q), .expect7(expect7), .rdata(rdata), .ok(poll_ok)
  );
endmodule

// File: rtl/nor_pe_ctrl_chk.sv
module nor_pe_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic err,
  input logic fl_ce_n,
  input logic fl_we_n,
  input logic fl_oe_n,
  input logic fl_dq_oe
);
  a_r5_write_strobes: assert property (@(posedge clk) disable iff (rst)
    !fl_we_n |-> (!fl_ce_n && fl_oe_n && fl_dq_oe));

  a_r6_read_strobes: assert property (@(posedge clk) disable iff (rst)
    !fl_oe_n |-> (!fl_ce_n && fl_we_n && !fl_dq_oe));

  a_r10_done_one_clock: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r10_busy_ends_with_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  a_r10_err_moves_with_done: assert property (@(posedge clk) disable iff (rst)
    !$stable(err) |-> done);

  a_r11_bus_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |-> fl_ce_n);
endmodule

bind nor_pe_ctrl nor_pe_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .err(err),
  .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n), .fl_dq_oe(fl_dq_oe)
);

// File: tb/nor_pe_ctrl_tb.sv
module nor_pe_ctrl_tb_top;
  localparam int AW = 19, WP = 3, RP = 2, GP = 2, TP = 200, TE = 400;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, poll_toggle = 1'b0;
  logic [1:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0] req_data = '0;
  logic busy, done, err, fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe;
  logic [AW-1:0] fl_addr;
  logic [7:0] fl_dq_o, fl_dq_i;

  int n_chk = 0, n_err = 0;
  int wr_cnt = 0, rd_cnt = 0, wlow = 0, rlow = 0, chigh = 0;
  int wp_bad = 0, rp_bad = 0, gap_bad = 0, bus_bad = 0, rd_addr_bad = 0;
  logic mon_started = 1'b0;
  logic [AW-1:0] wa [0:15];
  logic [7:0] wd [0:15];
  logic p_we = 1'b1, p_oe = 1'b1, p_ce = 1'b1;
  int m_busy = 0;
  logic m_busy7 = 1'b0, m_done7 = 1'b1;
  logic [AW-1:0] cur_addr = '0;

  always #10 clk = ~clk;

  nor_pe_ctrl #(.AW(AW), .WR_PULSE(WP), .RD_PULSE(RP), .GAP(GP),
                .TMO_PROG(TP), .TMO_ERASE(TE)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .poll_toggle(poll_toggle),
    .busy(busy), .done(done), .err(err), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n),
    .fl_oe_n(fl_oe_n), .fl_addr(fl_addr), .fl_dq_o(fl_dq_o),
    .fl_dq_oe(fl_dq_oe), .fl_dq_i(fl_dq_i)
  );

  // Flash model: read k (counted from 1) is busy while k <= m_busy.
  always_comb begin
    if (rd_cnt <= m_busy) fl_dq_i = {m_busy7, rd_cnt[0], 6'h0};
    else                  fl_dq_i = {m_done7, 1'b1, 6'h0};
  end

  always @(negedge clk) begin
    if (!fl_we_n) begin
      if (p_we) begin
        if (wr_cnt < 16) begin wa[wr_cnt] = fl_addr; wd[wr_cnt] = fl_dq_o; end
        wr_cnt++;
        if (fl_oe_n !== 1'b1 || fl_dq_oe !== 1'b1 || fl_ce_n !== 1'b0) bus_bad++;
      end
      wlow++;
    end else if (!p_we) begin
      if (wlow != WP) wp_bad++;
      wlow = 0;
    end
    if (!fl_oe_n) begin
      if (p_oe) begin
        rd_cnt++;
        if (fl_addr !== cur_addr) rd_addr_bad++;
        if (fl_we_n !== 1'b1 || fl_dq_oe !== 1'b0 || fl_ce_n !== 1'b0) bus_bad++;
      end
      rlow++;
    end else if (!p_oe) begin
      if (rlow != RP) rp_bad++;
      rlow = 0;
    end
    if (fl_ce_n) chigh++;
    else if (p_ce) begin
      if (mon_started && chigh < GP) gap_bad++;
      mon_started = 1'b1;
      chigh = 0;
    end
    p_we = fl_we_n; p_oe = fl_oe_n; p_ce = fl_ce_n;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW+7:0] exp_step(int op, int i, logic [AW-1:0] a, logic [7:0] d);
    case (i)
      0: return {AW'(16'h5555), 8'hAA};
      1: return {AW'(16'h2AAA), 8'h55};
      2: return (op == 0) ? {AW'(16'h5555), 8'hA0} : {AW'(16'h5555), 8'h80};
      3: return (op == 0) ? {a, d} : {AW'(16'h5555), 8'hAA};
      4: return {AW'(16'h2AAA), 8'h55};
      default: return (op == 1) ? {a, 8'h30} : {AW'(16'h5555), 8'h10};
    endcase
  endfunction

  function automatic int exp_reads(bit tog, int b);
    int prev, cur;
    if (!tog) return b + 1;
    prev = (b >= 1) ? 1 : 1;
    for (int k = 2; k < b + 4; k++) begin
      prev = (k - 1 <= b) ? ((k - 1) % 2) : 1;
      cur  = (k <= b) ? (k % 2) : 1;
      if (cur == prev) return k;
    end
    return -1;
  endfunction

  task automatic run_op(input int op, input logic [AW-1:0] a, input logic [7:0] d,
                        input bit tog, input int b, input bit poke, output int lat,
                        output logic got_err);
    int n;
    bit seen;
    @(negedge clk);
    wr_cnt = 0; rd_cnt = 0; mon_started = 1'b0; chigh = 0;
    m_busy = b; cur_addr = a;
    m_busy7 = (op == 0) ? ~d[7] : 1'b0;
    m_done7 = (op == 0) ?  d[7] : 1'b1;
    req_valid = 1'b1; req_op = op[1:0]; req_addr = a; req_data = d; poll_toggle = tog;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1; seen = 1'b0; got_err = 1'b0;
    if (op != 3) chk(busy === 1'b1 && done === 1'b0, "R10 busy after accept", busy, 1);
    n = 0;
    while (!seen && n < 20000) begin
      if (done === 1'b1) begin
        seen = 1'b1; got_err = err;
        chk(busy === 1'b0, "R10 busy low with done", busy, 0);
      end else begin
        if (poke && n == 5) begin
          req_valid = 1'b1; req_op = 2'd2; req_addr = ~a; poll_toggle = ~tog;
        end else req_valid = 1'b0;
        @(negedge clk);
        lat++; n++;
      end
    end
    req_valid = 1'b0;
    chk(seen, "R10 done arrives (watchdog)", n, 0);
    @(negedge clk);
    chk(done === 1'b0, "R10 done one clock", done, 0);
    chk(err === got_err, "R10 err held after done", err, got_err);
  endtask

  task automatic check_good(input int op, input logic [AW-1:0] a, input logic [7:0] d,
                            input bit tog, input int b, input bit poke);
    int lat, nw, bad;
    logic e;
    string rq;
    run_op(op, a, d, tog, b, poke, lat, e);
    nw = (op == 0) ? 4 : 6;
    rq = (op == 0) ? "R2 program sequence" : (op == 1) ? "R3 sector sequence" : "R4 chip sequence";
    chk(wr_cnt == nw, rq, wr_cnt, nw);
    bad = 0;
    for (int i = 0; i < nw && i < wr_cnt; i++)
      if ({wa[i], wd[i]} !== exp_step(op, i, a, d)) bad++;
    chk(bad == 0, rq, bad, 0);
    chk(e === 1'b0, tog ? "R8 toggle poll ok" : "R7 data poll ok", e, 0);
    chk(rd_cnt == exp_reads(tog, b), tog ? "R8 toggle read count" : "R7 data read count",
        rd_cnt, exp_reads(tog, b));
    if (poke) chk(wr_cnt == nw, "R11 request while busy ignored", wr_cnt, nw);
  endtask

  task automatic check_bus();
    chk(wp_bad == 0, "R5 write pulse width", wp_bad, 0);
    chk(gap_bad == 0, "R5 gap between cycles", gap_bad, 0);
    chk(rp_bad == 0, "R6 read pulse width", rp_bad, 0);
    chk(rd_addr_bad == 0, "R6 read address", rd_addr_bad, 0);
    chk(bus_bad == 0, "R5 R6 strobe levels", bus_bad, 0);
  endtask

  initial begin
    #(200000 * 20);
    chk(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int lat;
    logic e;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(fl_ce_n === 1 && fl_we_n === 1 && fl_oe_n === 1 && fl_dq_oe === 0,
        "R1 bus idle in reset", {fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe}, 4'b1110);
    rst = 1'b0;
    @(negedge clk);
    chk(busy === 0 && done === 0 && err === 0, "R1 status after reset",
        {busy, done, err}, 0);

    // Directed corners
    check_good(0, 19'h12345, 8'h80, 1'b0, 0, 1'b0);
    check_good(0, 19'h00001, 8'h00, 1'b0, 3, 1'b0);
    check_good(1, 19'h70000, 8'h00, 1'b1, 0, 1'b0);
    check_good(2, 19'h00000, 8'h00, 1'b1, 3, 1'b0);
    check_good(1, 19'h3C000, 8'h00, 1'b0, 2, 1'b1);

    // R12 rejected opcode
    run_op(3, 19'h1, 8'h1, 1'b0, 0, 1'b0, lat, e);
    chk(e === 1'b1 && lat == 1, "R12 invalid op rejected", {lat[3:0], e}, 5'b00011);
    chk(wr_cnt == 0 && rd_cnt == 0, "R12 no bus cycle", wr_cnt + rd_cnt, 0);

    // R9 timeouts
    run_op(0, 19'h00400, 8'h5A, 1'b0, 100000, 1'b0, lat, e);
    chk(e === 1'b1, "R9 program timeout err", e, 1);
    chk(lat >= TP && lat <= TP + 150, "R9 program timeout window", lat, TP);
    run_op(2, 19'h0, 8'h0, 1'b1, 100000, 1'b0, lat, e);
    chk(e === 1'b1, "R9 erase timeout err", e, 1);
    chk(lat >= TE && lat <= TE + 150, "R9 erase timeout window", lat, TE);
    check_good(0, 19'h00400, 8'h5A, 1'b1, 1, 1'b0);

    // Random mix
    for (int t = 0; t < 24; t++) begin
      int op, b;
      bit tog, poke;
      op   = $urandom_range(0, 2);
      tog  = 1'($urandom_range(0, 1));
      b    = $urandom_range(0, 7);
      poke = ($urandom_range(0, 3) == 0);
      check_good(op, AW'($urandom), 8'($urandom), tog, b, poke);
    end
    check_bus();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule